// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It runs a reduced instruction set: word load and word store, register-to-register add, subtract, AND, OR and signed set-less-than, a branch taken when two registers are equal, and an unconditional jump. Fetch, register read, ALU work, memory access and write-back all happen in the same cycle. The program counter, the register file and the data memory change only on the rising clock edge.

The core holds its own small instruction and data word arrays. While reset is held, a testbench or boot agent fills them through a load port. Two peek ports let it read any register and any data word. The control unit decodes in two levels. A main decoder turns the opcode into datapath strobes and a two-bit ALU class. A second decoder combines that class with the funct field to choose one of five three-bit ALU operations.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the PC becomes 0 and every register is cleared to 0. A cycle with reset high performs no data-memory store.
- R2: The register format has opcode 000000 in bits [31:26], first source in [25:21], second source in [20:16] and destination in [15:11]. Its funct field [5:0] selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR. The result is written to the register named in [15:11].
- R3: funct 101010 in register format writes 1 to the destination if the first source is less than the second, compared as signed 32-bit values, and writes 0 otherwise.
- R4: Opcode 100011 (load) writes the data word at byte address rs + sign-extended imm[15:0] into register rt ([20:16]).
- R5: Opcode 101011 (store) writes register rt to the data word at byte address rs + sign-extended imm[15:0] and does not change any register.
- R6: Opcode 000100 (branch-if-equal) sets the next PC to PC+4 + (sign-extended imm << 2) when rs equals rt. Otherwise the next PC is PC+4. Negative offsets are allowed.
- R7: Opcode 000010 (jump) sets the next PC to {PC+4 bits [31:28], bits [25:0] of the instruction, 2'b00}.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: Any other opcode changes no register and no data word, and the PC advances by 4.
- R10: Each clock cycle out of reset completes exactly one instruction. For instructions that are not branches or jumps, the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Write strobe for the preload port |
| loadSel | input | 1 | Preload target: 0 instruction array, 1 data array |
| loadAddr | input | LAW | Word index for the preload write |
| loadData | input | 32 | Word to preload |
| pcOut | output | 32 | Current program counter |
| peekReg | input | 5 | Register index to observe |
| peekRegData | output | 32 | Contents of the observed register (zero for index 0) |
| peekMemAddr | input | DAW | Data-array word index to observe |
| peekMemData | output | 32 | Contents of the observed data word |

## Verification
The hardest situation to reach from the ports is a chain of control transfers: a taken branch, then a branch that is not taken, then a jump, then a taken branch with a negative offset. Each transfer must land on a PC that only that path produces. The bench preloads one program in which the skipped slots hold loads that would leave a visible register value if they ran. It then samples the PC after every single cycle of that program, so a wrong target or an off-by-one in the offset scaling shows up in the cycle it happens.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  // Three-bit ALU operation codes
  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  // Two-bit ALU class produced by the main decoder
  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_REG = 2'b10
  } alu_cls_e;

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  // Strobes from control to datapath
  typedef struct packed {
    logic    regDst;
    logic    aluSrc;
    logic    memToReg;
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    branch;
    logic    jump;
    alu_op_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  alu_op_e         aluOp,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  always_comb begin
    unique case (aluOp)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  rdAddrA,
  input  logic [RAW-1:0]  rdAddrB,
  input  logic [RAW-1:0]  rdAddrC,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB,
  output logic [XLEN-1:0] rdDataC,
  input  logic            wrEn,
  input  logic [RAW-1:0]  wrAddr,
  input  logic [XLEN-1:0] wrData
);

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
  assign rdDataC = (rdAddrC == '0) ? '0 : regs[rdAddrC];

  // R8: the storage cell behind register 0 never takes a value
  p_zero_cell_r8: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

  // R1: a reset cycle leaves every register cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (regs[1] == '0 && regs[NREGS-1] == '0));

endmodule

// File: rtl/sc_control.sv
module sc_control
  import sc_core_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  alu_cls_e aluCls;
  ctrl_t    mainDec;

  // First level: opcode to strobes and ALU class
  always_comb begin
    mainDec = '0;
    aluCls  = CLS_MEM;
    unique case (opcode)
      OP_REG: begin
        mainDec.regDst   = 1'b1;
        mainDec.regWrite = 1'b1;
        aluCls           = CLS_REG;
      end
      OP_LOAD: begin
        mainDec.aluSrc   = 1'b1;
        mainDec.memToReg = 1'b1;
        mainDec.regWrite = 1'b1;
        mainDec.memRead  = 1'b1;
      end
      OP_STORE: begin
        mainDec.aluSrc   = 1'b1;
        mainDec.memWrite = 1'b1;
      end
      OP_BEQ: begin
        mainDec.branch = 1'b1;
        aluCls         = CLS_BR;
      end
      OP_JUMP: begin
        mainDec.jump = 1'b1;
      end
      default: mainDec = '0;
    endcase
  end

  // Second level: class plus funct to ALU operation
  alu_op_e aluSel;
  always_comb begin
    unique case (aluCls)
      CLS_MEM: aluSel = ALU_ADD;
      CLS_BR:  aluSel = ALU_SUB;
      CLS_REG: begin
        unique case (funct)
          FN_ADD:  aluSel = ALU_ADD;
          FN_SUB:  aluSel = ALU_SUB;
          FN_AND:  aluSel = ALU_AND;
          FN_OR:   aluSel = ALU_OR;
          FN_SLT:  aluSel = ALU_SLT;
          default: aluSel = ALU_ADD;
        endcase
      end
      default: aluSel = ALU_ADD;
    endcase
  end

  always_comb begin
    ctrl       = mainDec;
    ctrl.aluOp = aluSel;
  end

  // R9: at most one memory or flow strobe per instruction
  p_single_kind_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.memRead, ctrl.memWrite, ctrl.branch, ctrl.jump}));

  // R5: a store never writes the register file
  p_store_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !ctrl.regWrite);

  // R3: register-format set-less-than reaches the ALU as the compare code
  p_slt_decode_r3: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_REG && funct == FN_SLT) |-> (ctrl.aluOp == ALU_SLT && ctrl.regDst));

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_core_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int XLEN = 32,
  localparam int IAW  = $clog2(IMEM_DEPTH),
  localparam int DAW  = $clog2(DMEM_DEPTH),
  localparam int LAW  = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  input  logic            loadEn,
  input  logic            loadSel,
  input  logic [LAW-1:0]  loadAddr,
  input  logic [XLEN-1:0] loadData,
  output logic [XLEN-1:0] pcOut,
  input  logic [4:0]      peekReg,
  output logic [XLEN-1:0] peekRegData,
  input  logic [DAW-1:0]  peekMemAddr,
  output logic [XLEN-1:0] peekMemData
);

  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] dmem [DMEM_DEPTH];

  logic [XLEN-1:0] pc, pcNext, pcPlus4, branchTarget, jumpTarget;
  logic [XLEN-1:0] instr, immExt, rsData, rtData, aluB, aluResult, memRdData, wbData;
  logic [4:0]      rsIdx, rtIdx, rdIdx, wrIdx;
  logic            aluZero, takeBranch;
  logic [DAW-1:0]  dIdx;

  // Fetch and field split
  assign instr  = imem[pc[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign funct  = instr[5:0];
  assign immExt = {{16{instr[15]}}, instr[15:0]};

  sc_regfile #(.XLEN(XLEN), .NREGS(32)) regfile_i (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdAddrC (peekReg),
    .rdDataA (rsData),
    .rdDataB (rtData),
    .rdDataC (peekRegData),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wrIdx),
    .wrData  (wbData)
  );

  assign aluB = ctrl.aluSrc ? immExt : rtData;

  sc_alu #(.XLEN(XLEN)) alu_i (
    .opA    (rsData),
    .opB    (aluB),
    .aluOp  (ctrl.aluOp),
    .result (aluResult),
    .zero   (aluZero)
  );

  // Data memory access
  assign dIdx      = aluResult[DAW+1:2];
  assign memRdData = dmem[dIdx];
  assign wbData    = ctrl.memToReg ? memRdData : aluResult;
  assign wrIdx     = ctrl.regDst ? rdIdx : rtIdx;

  always_ff @(posedge clk) begin
    if (loadEn && !loadSel) imem[loadAddr[IAW-1:0]] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (loadEn && loadSel)              dmem[loadAddr[DAW-1:0]] <= loadData;
    else if (!rst && ctrl.memWrite)     dmem[dIdx] <= rtData;
  end

  // Next PC selection
  assign pcPlus4      = pc + 32'd4;
  assign branchTarget = pcPlus4 + {immExt[29:0], 2'b00};
  assign jumpTarget   = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign takeBranch   = ctrl.branch && aluZero;

  always_comb begin
    if (ctrl.jump)       pcNext = jumpTarget;
    else if (takeBranch) pcNext = branchTarget;
    else                 pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign pcOut       = pc;
  assign peekMemData = dmem[peekMemAddr];

  // R10: sequential instructions step the PC by one word
  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !(ctrl.branch && rsData == rtData)) |=> (pc == $past(pc) + 32'd4));

  // R6: equal operands on a branch redirect by the scaled offset
  p_branch_dest_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rsData == rtData) |=>
      (pc == $past(pc) + 32'd4 + {$past(instr[13:0]) == $past(instr[13:0]) ? {{16{$past(instr[15])}}, $past(instr[15:0])} : 32'd0} * 32'd4));

  // R7: jump keeps the upper PC nibble and takes the target field
  p_jump_dest_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc[27:2] == $past(instr[25:0]) && pc[1:0] == 2'b00));

  // R5: a store lands in the addressed word on the next edge
  p_store_commit_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.memWrite && !loadEn) |=> (dmem[$past(dIdx)] == $past(rtData)));

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           loadEn,
  input  logic           loadSel,
  input  logic [LAW-1:0] loadAddr,
  input  logic [31:0]    loadData,
  output logic [31:0]    pcOut,
  input  logic [4:0]     peekReg,
  output logic [31:0]    peekRegData,
  input  logic [DAW-1:0] peekMemAddr,
  output logic [31:0]    peekMemData
);

  ctrl_t      ctrl;
  logic [5:0] opcode;
  logic [5:0] funct;

  sc_control control_i (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  sc_datapath #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) datapath_i (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .opcode      (opcode),
    .funct       (funct),
    .loadEn      (loadEn),
    .loadSel     (loadSel),
    .loadAddr    (loadAddr),
    .loadData    (loadData),
    .pcOut       (pcOut),
    .peekReg     (peekReg),
    .peekRegData (peekRegData),
    .peekMemAddr (peekMemAddr),
    .peekMemData (peekMemData)
  );

endmodule

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;

  localparam int LAW = 6;
  localparam int DAW = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           loadEn = 1'b0;
  logic           loadSel = 1'b0;
  logic [LAW-1:0] loadAddr = '0;
  logic [31:0]    loadData = '0;
  logic [31:0]    pcOut;
  logic [4:0]     peekReg = '0;
  logic [31:0]    peekRegData;
  logic [DAW-1:0] peekMemAddr = '0;
  logic [31:0]    peekMemData;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadSel(loadSel),
    .loadAddr(loadAddr), .loadData(loadData), .pcOut(pcOut),
    .peekReg(peekReg), .peekRegData(peekRegData),
    .peekMemAddr(peekMemAddr), .peekMemData(peekMemData)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] encJ(logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadWord(logic sel, int addr, logic [31:0] data);
    loadSel  = sel;
    loadAddr = addr[LAW-1:0];
    loadData = data;
    loadEn   = 1'b1;
    @(negedge clk);
    loadEn   = 1'b0;
  endtask

  task automatic enterReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) loadWord(1'b0, i, 32'd0);
  endtask

  task automatic runCycles(int n);
    rst = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(int idx, output logic [31:0] v);
    peekReg = idx[4:0];
    #1 v = peekRegData;
  endtask

  task automatic readMem(int idx, output logic [31:0] v);
    peekMemAddr = idx[DAW-1:0];
    #1 v = peekMemData;
  endtask

  // R2, R3, R4, R5, R10
  task automatic testArith();
    logic [31:0] v;
    enterReset();
    loadWord(1'b1, 0, 32'h0000_0015);
    loadWord(1'b1, 1, 32'hFFFF_FFF9);
    loadWord(1'b1, 2, 32'h0);
    loadWord(1'b1, 3, 32'h0);
    loadWord(1'b0, 0, encI(6'b100011, 0, 1, 16'd0));
    loadWord(1'b0, 1, encI(6'b100011, 0, 2, 16'd4));
    loadWord(1'b0, 2, encR(1, 2, 3, 6'b100000));
    loadWord(1'b0, 3, encR(1, 2, 4, 6'b100010));
    loadWord(1'b0, 4, encR(1, 2, 5, 6'b100100));
    loadWord(1'b0, 5, encR(1, 2, 6, 6'b100101));
    loadWord(1'b0, 6, encR(2, 1, 7, 6'b101010));
    loadWord(1'b0, 7, encR(1, 2, 8, 6'b101010));
    loadWord(1'b0, 8, encI(6'b101011, 0, 3, 16'd8));
    loadWord(1'b0, 9, encI(6'b101011, 0, 4, 16'd12));
    runCycles(10);
    check("R10 pc after ten instructions", pcOut, 32'd40);
    readReg(1, v); check("R4 load word 0", v, 32'h15);
    readReg(2, v); check("R4 load word 1", v, 32'hFFFF_FFF9);
    readReg(3, v); check("R2 add", v, 32'd14);
    readReg(4, v); check("R2 sub / R5 no reg write", v, 32'd28);
    readReg(5, v); check("R2 and", v, 32'h11);
    readReg(6, v); check("R2 or", v, 32'hFFFF_FFFD);
    readReg(7, v); check("R3 slt negative<positive", v, 32'd1);
    readReg(8, v); check("R3 slt positive<negative", v, 32'd0);
    readMem(2, v); check("R5 store word 2", v, 32'd14);
    readMem(3, v); check("R5 store word 3", v, 32'd28);
  endtask

  // R1
  task automatic testReset();
    logic [31:0] v;
    enterReset();
    check("R1 pc cleared", pcOut, 32'd0);
    readReg(3, v); check("R1 register cleared", v, 32'd0);
    readMem(2, v); check("R1 data kept through reset", v, 32'd14);
  endtask

  // R6, R7
  task automatic testFlow();
    logic [31:0] v;
    enterReset();
    loadWord(1'b1, 0, 32'd5);
    loadWord(1'b0, 0,  encI(6'b100011, 0, 1, 16'd0));
    loadWord(1'b0, 1,  encI(6'b100011, 0, 2, 16'd0));
    loadWord(1'b0, 2,  encI(6'b000100, 1, 2, 16'd2));
    loadWord(1'b0, 3,  encI(6'b100011, 0, 3, 16'd0));
    loadWord(1'b0, 4,  encI(6'b100011, 0, 3, 16'd0));
    loadWord(1'b0, 5,  encI(6'b000100, 1, 0, 16'd5));
    loadWord(1'b0, 6,  encJ(26'd10));
    loadWord(1'b0, 7,  encI(6'b100011, 0, 4, 16'd0));
    loadWord(1'b0, 8,  encI(6'b100011, 0, 5, 16'd0));
    loadWord(1'b0, 9,  encJ(26'd25));
    loadWord(1'b0, 10, encI(6'b000100, 0, 0, 16'hFFFD));
    runCycles(3);
    check("R6 taken forward branch", pcOut, 32'd20);
    runCycles(1);
    check("R6 untaken branch", pcOut, 32'd24);
    runCycles(1);
    check("R7 jump target", pcOut, 32'd40);
    runCycles(1);
    check("R6 taken backward branch", pcOut, 32'd32);
    runCycles(2);
    check("R7 second jump", pcOut, 32'd100);
    readReg(3, v); check("R6 skipped slot not run", v, 32'd0);
    readReg(4, v); check("R7 skipped slot not run", v, 32'd0);
    readReg(5, v); check("R6 branch landing executed", v, 32'd5);
  endtask

  // R8
  task automatic testZeroReg();
    logic [31:0] v;
    enterReset();
    loadWord(1'b1, 0, 32'd9);
    loadWord(1'b0, 0, encI(6'b100011, 0, 1, 16'd0));
    loadWord(1'b0, 1, encR(1, 1, 0, 6'b100000));
    loadWord(1'b0, 2, encR(0, 1, 9, 6'b100000));
    runCycles(3);
    readReg(0, v); check("R8 r0 reads zero", v, 32'd0);
    readReg(9, v); check("R8 r0 source is zero", v, 32'd9);
  endtask

  // R9
  task automatic testUnknown();
    logic [31:0] v;
    enterReset();
    loadWord(1'b1, 0, 32'h77);
    loadWord(1'b1, 1, 32'hAAAA);
    loadWord(1'b0, 0, encI(6'b100011, 0, 1, 16'd0));
    loadWord(1'b0, 1, encI(6'b111111, 0, 1, 16'd4));
    loadWord(1'b0, 2, encI(6'b001000, 0, 1, 16'd5));
    loadWord(1'b0, 3, encI(6'b101001, 0, 1, 16'd4));
    runCycles(4);
    check("R9 pc advances by 4", pcOut, 32'd16);
    readReg(1, v); check("R9 register untouched", v, 32'h77);
    readMem(1, v); check("R9 memory untouched", v, 32'hAAAA);
  endtask

  initial begin
    #(20 * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    testArith();
    testReset();
    testFlow();
    testZeroReg();
    testUnknown();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule